// File: doc/BRIEF.md
# In-memory bitwise logic array

This block models a compute-capable memory of 64 rows by 320 bits that a processor drives through a one-word command port. Besides plain 32-bit word reads and writes, it runs whole-row operations inside the array. XOR, OR and AND combine two source rows across all 320 columns at once. A rotate turns every 64-bit group of a row left. A group copy moves one 64-bit group into another group position, and a broadcast copy writes one 64-bit group into all five groups of a row. Every row operation writes its result into a destination row. The cell physics is not modelled. The combined result of two activated rows is computed as Boolean values: OR and AND come from the pair of cells, and XOR is formed as OR and not AND.

Commands enter on a valid/ready port, and the 32-bit command word is decoded inside the block. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. The producer may hold `cmd_valid` with stable fields for as long as `cmd_ready` is low. A row operation samples both source rows when it is taken and writes back one cycle later. During that write-back cycle `cmd_ready` is low, so a destination that is also a source gets the result computed from its old contents. Read data has no back-pressure. It is presented for one cycle with `rd_valid`, and the processor must capture it in that cycle.

Top module: `imc_logic_array`

## Requirements
- R1: After reset every bit of every row reads 0, `cmd_ready` is 1 and `rd_valid` is 0.
- R2: Class 7'h2B (bits 6:0) reads 32-bit word w (bits 23:20) of a row, meaning columns 32w+31 down to 32w. Class 7'h5B writes `cmd_wdata` into that word. `rd_data` and a one-cycle `rd_valid` pulse appear in the cycle after the read is taken. A read of word 10 to 15 returns 0, and a write to word 10 to 15 changes nothing.
- R3: Every row index is 6 bits: instruction bit 15 on top of a 5-bit row field. The read/write row field is bits 11:7. For logic and shift, the first source is bits 29:25, the second source is bits 24:20 and the destination is bits 11:7. For copies, the source is bits 24:20 and the destination is bits 11:7.
- R4: Class 7'h0B with bits 31:30 = 00 writes the XOR of the two source rows to the destination.
- R5: Class 7'h0B with bits 31:30 = 01 writes the OR of the two source rows.
- R6: Class 7'h0B with bits 31:30 = 10 writes the AND of the two source rows.
- R7: Class 7'h0B with bits 31:30 = 11 rotates each 64-bit group of the first source row left by {bits 24:20, bit 12}. No bit moves between groups.
- R8: Class 7'h7B with bit 31 = 0 copies source group bits 30:28 into destination group bits 27:25 and leaves the other groups of the destination unchanged. A destination group of 5 to 7 writes nothing.
- R9: Class 7'h7B with bit 31 = 1 writes source group bits 30:28 into all five groups of the destination row.
- R10: After a row operation is taken, `cmd_ready` is 0 for exactly one cycle. A command accepted after that sees the written row.
- R11: When the destination is also a source, the result is computed from the row contents as they were before the write-back.
- R12: A command with any other class is taken and changes no row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_instr | input | 32 | Command word |
| cmd_wdata | input | 32 | Data for a word write |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 32 | Word read result |

## Verification
A fault inside this block stays hidden until a row is read back. The bench therefore follows every row operation with word reads of the destination, of the groups that must not change, and of neighbouring rows. A wrong write mask, group select or rotate shows up in the first word read of the affected 64-bit group, one cycle after that read is taken. A fault in the handshake or in source sampling shows up as `cmd_ready` holding the wrong level in the cycle right after the operation is taken, or as a destination that was also a source returning a result built from its new contents.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int IDX_W  = 6;
  localparam int SH_W   = 6;
  localparam int GSEL_W = 3;
  localparam int WSEL_W = 4;

  localparam logic [6:0] CLS_LOGIC = 7'h0B;
  localparam logic [6:0] CLS_READ  = 7'h2B;
  localparam logic [6:0] CLS_WRITE = 7'h5B;
  localparam logic [6:0] CLS_COPY  = 7'h7B;

  typedef enum logic [1:0] {K_NOP, K_READ, K_WRITE, K_ROW} kind_e;
  typedef enum logic [2:0] {RO_XOR, RO_OR, RO_AND, RO_SHL, RO_CP, RO_CPA} rop_e;

  typedef struct packed {
    kind_e              kind;
    rop_e               rop;
    logic [IDX_W-1:0]   src_a;
    logic [IDX_W-1:0]   src_b;
    logic [IDX_W-1:0]   dst;
    logic [SH_W-1:0]    shamt;
    logic [GSEL_W-1:0]  sgrp;
    logic [GSEL_W-1:0]  dgrp;
    logic [WSEL_W-1:0]  word;
  } cmd_t;
endpackage

// File: rtl/imc_decode.sv
module imc_decode
  import imc_pkg::*;
(
  input  logic [31:0] instr_i,
  output cmd_t        cmd_o
);
  logic [IDX_W-1:0] row_d;
  logic             unused_bits;

  assign row_d       = {instr_i[15], instr_i[11:7]};
  assign unused_bits = ^{instr_i[19:16], instr_i[14:13]};

  always_comb begin
    cmd_o      = '0;
    cmd_o.kind = K_NOP;
    cmd_o.rop  = RO_XOR;
    cmd_o.dst  = row_d;
    unique case (instr_i[6:0])
      CLS_LOGIC: begin
        cmd_o.kind  = K_ROW;
        cmd_o.src_a = {instr_i[15], instr_i[29:25]};
        cmd_o.src_b = {instr_i[15], instr_i[24:20]};
        cmd_o.shamt = {instr_i[24:20], instr_i[12]};
        case (instr_i[31:30])
          2'b00:   cmd_o.rop = RO_XOR;
          2'b01:   cmd_o.rop = RO_OR;
          2'b10:   cmd_o.rop = RO_AND;
          default: cmd_o.rop = RO_SHL;
        endcase
      end
      CLS_COPY: begin
        cmd_o.kind  = K_ROW;
        cmd_o.rop   = instr_i[31] ? RO_CPA : RO_CP;
        cmd_o.src_a = {instr_i[15], instr_i[24:20]};
        cmd_o.src_b = {instr_i[15], instr_i[24:20]};
        cmd_o.sgrp  = instr_i[30:28];
        cmd_o.dgrp  = instr_i[27:25];
      end
      CLS_READ: begin
        cmd_o.kind = K_READ;
        cmd_o.word = instr_i[23:20];
      end
      CLS_WRITE: begin
        cmd_o.kind = K_WRITE;
        cmd_o.word = instr_i[23:20];
      end
      default: cmd_o.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/imc_rowop.sv
module imc_rowop
  import imc_pkg::*;
#(
  parameter int COLS  = 320,
  parameter int GRP_W = 64,
  parameter int NGRP  = COLS / GRP_W
) (
  input  logic [COLS-1:0]   a_i,
  input  logic [COLS-1:0]   b_i,
  input  rop_e              op_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [GSEL_W-1:0] sgrp_i,
  input  logic [GSEL_W-1:0] dgrp_i,
  output logic [COLS-1:0]   res_o,
  output logic [NGRP-1:0]   mask_o
);
  localparam int SHW = $clog2(GRP_W);

  logic [COLS-1:0]  or_v, and_v, xor_v, shl_v, rep_v;
  logic [GRP_W-1:0] src_grp;
  logic [NGRP-1:0]  cp_mask;

  // pair evaluation: OR and AND per column, XOR derived from both
  assign or_v  = a_i | b_i;
  assign and_v = a_i & b_i;
  assign xor_v = or_v & ~and_v;

  always_comb begin
    src_grp = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (int'(sgrp_i) == g) src_grp = a_i[g*GRP_W +: GRP_W];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [2*GRP_W-1:0] dbl;
    assign dbl = {a_i[g*GRP_W +: GRP_W], a_i[g*GRP_W +: GRP_W]} << shamt_i[SHW-1:0];
    assign shl_v[g*GRP_W +: GRP_W] = dbl[2*GRP_W-1 -: GRP_W];
    assign rep_v[g*GRP_W +: GRP_W] = src_grp;
    assign cp_mask[g] = (int'(dgrp_i) == g);
  end

  always_comb begin
    mask_o = '1;
    case (op_i)
      RO_XOR:  res_o = xor_v;
      RO_OR:   res_o = or_v;
      RO_AND:  res_o = and_v;
      RO_SHL:  res_o = shl_v;
      RO_CP: begin
        res_o  = rep_v;
        mask_o = cp_mask;
      end
      RO_CPA:  res_o = rep_v;
      default: begin
        res_o  = '0;
        mask_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/imc_store.sv
module imc_store #(
  parameter int ROWS   = 64,
  parameter int COLS   = 320,
  parameter int WORD_W = 32,
  parameter int GRP_W  = 64,
  parameter int NGRP   = COLS / GRP_W,
  parameter int NWORD  = COLS / WORD_W,
  parameter int ROW_AW = $clog2(ROWS),
  parameter int WSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ROW_AW-1:0] ra_idx,
  output logic [COLS-1:0]   ra_row,
  input  logic [ROW_AW-1:0] rb_idx,
  output logic [COLS-1:0]   rb_row,
  input  logic              wr_row_en,
  input  logic [ROW_AW-1:0] wr_idx,
  input  logic [COLS-1:0]   wr_row,
  input  logic [NGRP-1:0]   wr_mask,
  input  logic              ww_en,
  input  logic [ROW_AW-1:0] ww_idx,
  input  logic [WSEL_W-1:0] ww_sel,
  input  logic [WORD_W-1:0] ww_data,
  input  logic [ROW_AW-1:0] rw_idx,
  input  logic [WSEL_W-1:0] rw_sel,
  output logic [WORD_W-1:0] rw_data
);
  logic [COLS-1:0] mem [ROWS];

  assign ra_row = mem[ra_idx];
  assign rb_row = mem[rb_idx];

  always_comb begin
    rw_data = '0;
    if (int'(rw_sel) < NWORD) rw_data = mem[rw_idx][int'(rw_sel)*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else if (wr_row_en) begin
      for (int g = 0; g < NGRP; g++) begin
        if (wr_mask[g]) mem[wr_idx][g*GRP_W +: GRP_W] <= wr_row[g*GRP_W +: GRP_W];
      end
    end else if (ww_en && int'(ww_sel) < NWORD) begin
      mem[ww_idx][int'(ww_sel)*WORD_W +: WORD_W] <= ww_data;
    end
  end

  // R9: a write-back with every group enabled lands the whole row
  a_r9_full_row_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_row_en && (&wr_mask)) |=> mem[$past(wr_idx)] == $past(wr_row));
endmodule

// File: rtl/imc_logic_array.sv
module imc_logic_array
  import imc_pkg::*;
#(
  parameter int ROWS   = 64,
  parameter int COLS   = 320,
  parameter int GRP_W  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [31:0]       cmd_instr,
  input  logic [WORD_W-1:0] cmd_wdata,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);
  localparam int NGRP   = COLS / GRP_W;
  localparam int NWORD  = COLS / WORD_W;
  localparam int ROW_AW = $clog2(ROWS);

  typedef enum logic {S_IDLE, S_WB} st_e;

  st_e               state;
  cmd_t              dec;
  logic              accept;
  logic [COLS-1:0]   row_a, row_b, samp_a, samp_b, wb_row;
  logic [NGRP-1:0]   wb_mask;
  rop_e              held_rop;
  logic [SH_W-1:0]   held_shamt;
  logic [GSEL_W-1:0] held_sgrp, held_dgrp;
  logic [IDX_W-1:0]  held_dst;
  logic [WORD_W-1:0] rw_data;

  imc_decode u_dec (.instr_i(cmd_instr), .cmd_o(dec));

  assign cmd_ready = (state == S_IDLE);
  assign accept    = cmd_valid && cmd_ready;

  imc_store #(
    .ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W), .GRP_W(GRP_W),
    .NGRP(NGRP), .NWORD(NWORD), .ROW_AW(ROW_AW), .WSEL_W(WSEL_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .ra_idx    (dec.src_a[ROW_AW-1:0]),
    .ra_row    (row_a),
    .rb_idx    (dec.src_b[ROW_AW-1:0]),
    .rb_row    (row_b),
    .wr_row_en (state == S_WB),
    .wr_idx    (held_dst[ROW_AW-1:0]),
    .wr_row    (wb_row),
    .wr_mask   (wb_mask),
    .ww_en     (accept && dec.kind == K_WRITE),
    .ww_idx    (dec.dst[ROW_AW-1:0]),
    .ww_sel    (dec.word),
    .ww_data   (cmd_wdata),
    .rw_idx    (dec.dst[ROW_AW-1:0]),
    .rw_sel    (dec.word),
    .rw_data   (rw_data)
  );

  imc_rowop #(.COLS(COLS), .GRP_W(GRP_W), .NGRP(NGRP)) u_rowop (
    .a_i     (samp_a),
    .b_i     (samp_b),
    .op_i    (held_rop),
    .shamt_i (held_shamt),
    .sgrp_i  (held_sgrp),
    .dgrp_i  (held_dgrp),
    .res_o   (wb_row),
    .mask_o  (wb_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      samp_a     <= '0;
      samp_b     <= '0;
      held_rop   <= RO_XOR;
      held_shamt <= '0;
      held_sgrp  <= '0;
      held_dgrp  <= '0;
      held_dst   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      rd_valid <= accept && dec.kind == K_READ;
      if (accept && dec.kind == K_READ) rd_data <= rw_data;
      if (state == S_WB) begin
        state <= S_IDLE;
      end else if (accept && dec.kind == K_ROW) begin
        state      <= S_WB;
        samp_a     <= row_a;
        samp_b     <= row_b;
        held_rop   <= dec.rop;
        held_shamt <= dec.shamt;
        held_sgrp  <= dec.sgrp;
        held_dgrp  <= dec.dgrp;
        held_dst   <= dec.dst;
      end
    end
  end

  a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.kind == K_ROW) |=> !cmd_ready);
  a_r10_ready_returns: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> cmd_ready);
  a_r2_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && dec.kind == K_READ) |=> rd_valid);
  a_r2_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(accept && dec.kind == K_READ));
  a_r4_xor_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && held_rop == RO_XOR) |-> wb_row == (samp_a ^ samp_b));
  a_r8_cp_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && held_rop == RO_CP) |-> $countones(wb_mask) <= 1);
  a_r9_cpa_all_groups: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && held_rop == RO_CPA) |-> (&wb_mask));
endmodule

// File: tb/imc_logic_array_bench.sv
`timescale 1ns/1ps
module imc_logic_array_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_instr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  imc_logic_array u_imc_logic_array (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_instr(cmd_instr), .cmd_wdata(cmd_wdata), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [31:0] wdata;
    logic        chk;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] enc_rw(logic [6:0] cls, int row, int word);
    logic [31:0] i = '0;
    i[6:0] = cls; i[11:7] = row[4:0]; i[15] = row[5]; i[23:20] = word[3:0];
    return i;
  endfunction
  function automatic logic [31:0] enc_lg(logic [1:0] op, int a, int b, int d);
    logic [31:0] i = '0;
    i[6:0] = 7'h0B; i[31:30] = op; i[29:25] = a[4:0]; i[24:20] = b[4:0];
    i[15] = d[5]; i[11:7] = d[4:0];
    return i;
  endfunction
  function automatic logic [31:0] enc_sh(int a, int d, int amt);
    logic [31:0] i = '0;
    i[6:0] = 7'h0B; i[31:30] = 2'b11; i[29:25] = a[4:0]; i[24:20] = amt[5:1];
    i[12] = amt[0]; i[15] = d[5]; i[11:7] = d[4:0];
    return i;
  endfunction
  function automatic logic [31:0] enc_cp(bit all, int sg, int dg, int s, int d);
    logic [31:0] i = '0;
    i[6:0] = 7'h7B; i[31] = all; i[30:28] = sg[2:0]; i[27:25] = dg[2:0];
    i[24:20] = s[4:0]; i[15] = d[5]; i[11:7] = d[4:0];
    return i;
  endfunction
  function automatic vec_t vr(int row, int word, logic [31:0] e, int rq);
    return '{enc_rw(7'h2B, row, word), 32'h0, 1'b1, e, rq[3:0]};
  endfunction
  function automatic vec_t vw(int row, int word, logic [31:0] d);
    return '{enc_rw(7'h5B, row, word), d, 1'b0, 32'h0, 4'd0};
  endfunction
  function automatic vec_t vc(logic [31:0] ins);
    return '{ins, 32'h0, 1'b0, 32'h0, 4'd0};
  endfunction

  localparam int NVEC = 46;
  localparam vec_t VEC [NVEC] = '{
    vr(0, 0, 32'h0, 1),                      // R1 cleared array
    vw(1, 0, 32'hF0F0_00FF),
    vw(2, 0, 32'hFF00_0F0F),
    vc(enc_lg(2'b00, 1, 2, 3)),
    vr(3, 0, 32'h0FF0_0FF0, 4),              // R4 xor
    vc(enc_lg(2'b01, 1, 2, 4)),
    vr(4, 0, 32'hFFF0_0FFF, 5),              // R5 or
    vc(enc_lg(2'b10, 1, 2, 5)),
    vr(5, 0, 32'hF000_000F, 6),              // R6 and
    vw(6, 0, 32'h8000_0001),
    vw(6, 1, 32'h0000_0003),
    vw(6, 2, 32'h0000_0001),
    vw(6, 3, 32'h8000_0000),
    vc(enc_sh(6, 7, 4)),
    vr(7, 0, 32'h0000_0010, 7),              // R7 rotate by 4
    vr(7, 1, 32'h0000_0038, 7),
    vr(7, 2, 32'h0000_0018, 7),              // R7 wrap inside group 1
    vr(7, 3, 32'h0000_0000, 7),
    vc(enc_sh(6, 11, 33)),
    vr(11, 0, 32'h0000_0007, 7),             // R7 amount uses bit 12
    vr(11, 1, 32'h0000_0002, 7),
    vc(enc_cp(1'b0, 1, 3, 6, 8)),
    vr(8, 6, 32'h0000_0001, 8),              // R8 single group copy
    vr(8, 7, 32'h8000_0000, 8),
    vr(8, 2, 32'h0, 8),
    vc(enc_cp(1'b1, 0, 0, 6, 9)),
    vr(9, 0, 32'h8000_0001, 9),              // R9 broadcast
    vr(9, 9, 32'h0000_0003, 9),
    vr(9, 4, 32'h8000_0001, 9),
    vw(40, 5, 32'hDEAD_BEEF),
    vr(8, 5, 32'h0, 3),                      // R3 upper-half write not aliased
    vr(40, 5, 32'hDEAD_BEEF, 3),
    vw(1, 12, 32'h1234_5678),
    vr(1, 12, 32'h0, 2),                     // R2 word index out of range
    vr(1, 0, 32'hF0F0_00FF, 2),
    vc(enc_lg(2'b00, 1, 2, 1)),
    vr(1, 0, 32'h0FF0_0FF0, 11),             // R11 destination is a source
    '{enc_rw(7'h13, 2, 0), 32'h0, 1'b0, 32'h0, 4'd0},
    vr(2, 0, 32'hFF00_0F0F, 12),             // R12 unknown class
    vc(enc_cp(1'b0, 0, 6, 6, 10)),
    vr(10, 0, 32'h0, 8),                     // R8 group 6 writes nothing
    vr(10, 8, 32'h0, 8),
    vw(33, 0, 32'h0000_FFFF),
    vc(enc_lg(2'b00, 40, 33, 34)),
    vr(34, 0, 32'h0000_FFFF, 3),             // R3 upper-half row op
    vr(2, 0, 32'hFF00_0F0F, 3)
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] ins, input logic [31:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_instr = ins; cmd_wdata = wd;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready", {31'b0, cmd_ready}, 32'd1);
    check("R1 rd_valid", {31'b0, rd_valid}, 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i].instr, VEC[i].wdata);
      if (VEC[i].chk) begin
        check($sformatf("R%0d vec %0d valid", VEC[i].req, i), {31'b0, rd_valid}, 32'd1);
        check($sformatf("R%0d vec %0d data", VEC[i].req, i), rd_data, VEC[i].exp);
      end
    end

    // R10: ready low for exactly the write-back cycle
    send(enc_lg(2'b01, 3, 5, 12), 32'h0);
    check("R10 ready low after op", {31'b0, cmd_ready}, 32'd0);
    @(negedge clk);
    check("R10 ready back", {31'b0, cmd_ready}, 32'd1);
    send(enc_rw(7'h2B, 12, 0), 32'h0);
    check("R10 result visible", rd_data, 32'hFFF0_0FFF);

    // R2: read pulse lasts one cycle, writes raise no pulse
    @(negedge clk);
    check("R2 pulse ends", {31'b0, rd_valid}, 32'd0);
    send(enc_rw(7'h5B, 12, 9), 32'hA5A5_5A5A);
    check("R2 no pulse on write", {31'b0, rd_valid}, 32'd0);
    send(enc_rw(7'h2B, 12, 9), 32'h0);
    check("R2 last word", rd_data, 32'hA5A5_5A5A);

    // R11 with the second source as destination
    send(enc_lg(2'b10, 4, 5, 5), 32'h0);
    send(enc_rw(7'h2B, 5, 0), 32'h0);
    check("R11 and into source", rd_data, 32'hF000_000F);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R1 ready after reset", {31'b0, cmd_ready}, 32'd1);
    check("R1 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
    send(enc_rw(7'h2B, 40, 5), 32'h0);
    check("R1 row cleared", rd_data, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule